// File: doc/BRIEF.md
# Double-Data-Rate Read Burst Sequencer

This block schedules read bursts on the device side of a double-data-rate memory interface. It runs on a fast clock at twice the command rate and produces its own half-cycle phase flag. A READ strobe, together with a bank, a column and a four-beat data word, is sampled in the first half of a command cycle. After the selected CAS latency the block puts the four beats on the data output, one per half cycle. It drives the read strobe with a preamble and a postamble, and it opens a window during which the data-line termination is switched off.

When a second READ follows two command cycles after the first, the two bursts form one unbroken eight-beat stream. The strobe enable and the termination window stay continuous across the join. Pending reads are kept in a shift pipeline of half-cycle markers, so several overlapping commands are each decoded independently. Their data waits in a small queue until it is delivered.

Top module: `ddr_rd_seq`

## Requirements
- R1: Each accepted READ delivers 4 beats in consecutive half cycles. During beat k (k = 0..3), `dq_o` carries `rd_data_i[k*DW +: DW]` as captured with the command, `beat_o` equals k, and `bank_o`/`col_o` show the command's address.
- R2: Beat 0 of a READ sampled in command cycle t appears in the first half of command cycle t+CL. CL is 5 when `cl6_i`=0 and 6 when `cl6_i`=1. `dq_oe_o` is high exactly during the 4 beats.
- R3: A READ sampled 2 command cycles after an accepted READ gives 8 beats with no gap, the second burst's beats directly after the first's.
- R4: The second READ of a gapless pair behaves the same whether it targets the same bank or a different bank.
- R5: `dqs_oe_o` rises one half cycle before beat 0, and in that half cycle `dqs_o` is 1.
- R6: While the strobe is driven, `dqs_o` is 0 on beats 0 and 2 and 1 on beats 1 and 3, so it changes level at every beat boundary.
- R7: After the last beat (level 1), `dqs_oe_o` falls at the next half-cycle boundary. No extra driven half cycle follows.
- R8: `odt_off_o` is high from one command cycle (2 half cycles) before beat 0 until one command cycle after the last beat ends.
- R9: For a gapless pair, `dqs_oe_o` and `odt_off_o` stay high without a break from the first preamble to the last postamble. With a 3-cycle spacing, the strobe is undriven for exactly one half cycle between the bursts, while the termination window stays continuous.
- R10: With no read in flight, `dqs_oe_o`, `dqs_o`, `dq_oe_o`, `odt_off_o`, `dq_o`, `beat_o`, `bank_o` and `col_o` are all 0.
- R11: A READ sampled one command cycle after an accepted READ is rejected. `rd_err_o` is 1 for the half cycle after the sampling edge, and the READ produces no beats, strobe or termination change.
- R12: `rd_i` is sampled only at edges where `ph_o`=0. A READ presented while `ph_o`=1 has no effect and raises no error.
- R13: After reset `ph_o` is 0, and it then alternates every fast-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the command rate |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_i | input | 1 | READ command strobe |
| bank_i | input | BANK_W | Bank address of the READ |
| col_i | input | COL_W | Column address of the READ |
| rd_data_i | input | 4*DW | Four beats of burst data, beat 0 in the low bits |
| cl6_i | input | 1 | CAS latency select: 0 gives 5, 1 gives 6 |
| ph_o | output | 1 | Half-cycle phase, 0 for the first half of a command cycle |
| dq_o | output | DW | Data beat |
| dq_oe_o | output | 1 | A data beat is valid |
| beat_o | output | 2 | Index of the beat within its burst |
| bank_o | output | BANK_W | Bank of the burst being delivered |
| col_o | output | COL_W | Column of the burst being delivered |
| dqs_o | output | 1 | Read strobe level |
| dqs_oe_o | output | 1 | Read strobe driven |
| odt_off_o | output | 1 | Data termination switched off |
| rd_err_o | output | 1 | READ rejected for being too close to the previous one |

## Verification
The bench builds the block with its defaults: DW=16, BANK_W=3, COL_W=10, CAS latency choices 5 and 6. The second choice sets the pipeline at 17 half-cycle stages and the data queue at 4 entries. A chain of four gapless READs at CL 6 therefore fills the queue to its last entry. Switching `cl6_i` between scenarios exercises both decode offsets. Spacings of one, two and three command cycles cover rejection, merging, and the one-half-cycle strobe gap.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
  // Beats per READ burst; the gapless spacing in command cycles follows.
  localparam int BEATS   = 4;
  localparam int GAP_CYC = BEATS / 2;

  // Half cycles after the sampling edge at which beat 0 is on the bus.
  function automatic int first_beat_age(input int cl);
    return 2 * cl - 1;
  endfunction

  // Termination window margins, in half cycles, around the data beats.
  function automatic int odt_first_age(input int cl);
    return first_beat_age(cl) - 2;
  endfunction

  function automatic int odt_last_age(input int cl);
    return first_beat_age(cl) + BEATS - 1 + 2;
  endfunction

  // Pipeline stages needed for the largest latency.
  function automatic int hist_depth(input int cl_max);
    return odt_last_age(cl_max) + 1;
  endfunction
endpackage

// File: rtl/rdseq_hist.sv
module rdseq_hist
  import rdseq_pkg::*;
#(
  parameter int HIST_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_i,
  input  logic              rd_i,
  output logic [HIST_W-1:0] hist_o,
  output logic              accept_o,
  output logic              reject_o
);
  localparam int NEAR_W = 2 * GAP_CYC - 2;

  logic [HIST_W-1:0] hist_q;
  logic              err_q;
  logic              too_close;

  assign too_close = |hist_q[NEAR_W-1:0];
  assign accept_o  = rd_i & ~phase_i & ~too_close;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      err_q  <= 1'b0;
    end else begin
      hist_q <= {hist_q[HIST_W-2:0], accept_o};
      err_q  <= rd_i & ~phase_i & too_close;
    end
  end

  assign hist_o   = hist_q;
  assign reject_o = err_q;

  // R3: accepted READs are never closer than the gapless spacing.
  a_r3_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    hist_q[0] |-> ($countones(hist_q[2*GAP_CYC-1:1]) == 0));
  // R12: a strobe in the second half cycle is never recorded.
  a_r12_phase_one_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && phase_i) |=> !hist_q[0]);
  // R11: a rejected READ raises the error flag and leaves no marker.
  a_r11_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !phase_i && too_close) |=> (err_q && !hist_q[0]));
endmodule

// File: rtl/rdseq_queue.sv
module rdseq_queue #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, empty;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem_q[wr_q] <= din_i;
  end

  assign head_o = empty ? '0 : mem_q[rd_q];

  // R3: the queue is sized so that legal spacing never overruns it.
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (!full || pop_i));
  // R1: a burst finishes only when its data was queued.
  a_r1_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty);
endmodule

// File: rtl/rdseq_wave.sv
module rdseq_wave
  import rdseq_pkg::*;
#(
  parameter int HIST_W = 17,
  parameter int CL_LO  = 5,
  parameter int CL_HI  = 6,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] hist_i,
  input  logic              cl6_i,
  output logic              dq_en_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              dqs_oe_o,
  output logic              dqs_o,
  output logic              odt_off_o
);
  int f_age;
  int o_lo, o_hi;

  always_comb begin
    f_age = first_beat_age(cl6_i ? CL_HI : CL_LO);
    o_lo  = odt_first_age(cl6_i ? CL_HI : CL_LO);
    o_hi  = odt_last_age(cl6_i ? CL_HI : CL_LO);
  end

  // Beat decode: one marker at most falls inside the beat window.
  always_comb begin
    dq_en_o = 1'b0;
    beat_o  = '0;
    for (int k = 0; k < BEATS; k++) begin
      if (hist_i[f_age + k]) begin
        dq_en_o = 1'b1;
        beat_o  = BEAT_W'(k);
      end
    end
  end

  // Strobe window: preamble half cycle plus the beats.
  always_comb begin
    dqs_oe_o = 1'b0;
    for (int m = 0; m < HIST_W; m++) begin
      if (m >= f_age - 1 && m <= f_age + BEATS - 1 && hist_i[m]) dqs_oe_o = 1'b1;
    end
  end

  // Termination window: one command cycle either side of the beats.
  always_comb begin
    odt_off_o = 1'b0;
    for (int m = 0; m < HIST_W; m++) begin
      if (m >= o_lo && m <= o_hi && hist_i[m]) odt_off_o = 1'b1;
    end
  end

  // Level: high in the preamble, then the beat parity.
  assign dqs_o = dqs_oe_o & (dq_en_o ? beat_o[0] : 1'b1);

  // R5: the strobe starts driven at level high.
  a_r5_preamble_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dqs_oe_o) |-> dqs_o);
  // R7: the last driven level before release is high.
  a_r7_postamble_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dqs_oe_o) |-> $past(dqs_o));
  // R6: the strobe changes level between consecutive beats.
  a_r6_toggle_per_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_en_o && $past(dq_en_o)) |-> (dqs_o != $past(dqs_o)));
  // R8: termination is off whenever the strobe is driven.
  a_r8_odt_covers_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_oe_o |-> odt_off_o);
  // R2: data is never valid without the strobe.
  a_r2_data_inside_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    dq_en_o |-> dqs_oe_o);
endmodule

// File: rtl/ddr_rd_seq.sv
module ddr_rd_seq
  import rdseq_pkg::*;
#(
  parameter int DW     = 16,
  parameter int BANK_W = 3,
  parameter int COL_W  = 10,
  parameter int CL_LO  = 5,
  parameter int CL_HI  = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_i,
  input  logic [BANK_W-1:0]     bank_i,
  input  logic [COL_W-1:0]      col_i,
  input  logic [BEATS*DW-1:0]   rd_data_i,
  input  logic                  cl6_i,
  output logic                  ph_o,
  output logic [DW-1:0]         dq_o,
  output logic                  dq_oe_o,
  output logic [1:0]            beat_o,
  output logic [BANK_W-1:0]     bank_o,
  output logic [COL_W-1:0]      col_o,
  output logic                  dqs_o,
  output logic                  dqs_oe_o,
  output logic                  odt_off_o,
  output logic                  rd_err_o
);
  localparam int HIST_W = hist_depth(CL_HI);
  localparam int Q_D    = (2 * CL_HI + 3) / (2 * GAP_CYC) + 1;
  localparam int DATA_W = BEATS * DW;
  localparam int ENT_W  = BANK_W + COL_W + DATA_W;
  localparam int BEAT_W = $clog2(BEATS);

  logic              ph_q;
  logic [HIST_W-1:0] hist;
  logic              accept, reject;
  logic              dq_en;
  logic [BEAT_W-1:0] beat;
  logic              pop;
  logic [ENT_W-1:0]  head;
  logic [DATA_W-1:0] head_data;

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ~ph_q;
  end
  assign ph_o = ph_q;

  rdseq_hist #(.HIST_W(HIST_W)) hist_i (
    .clk(clk), .rst_n(rst_n), .phase_i(ph_q), .rd_i(rd_i),
    .hist_o(hist), .accept_o(accept), .reject_o(reject)
  );

  rdseq_wave #(.HIST_W(HIST_W), .CL_LO(CL_LO), .CL_HI(CL_HI), .BEAT_W(BEAT_W)) wave_i (
    .clk(clk), .rst_n(rst_n), .hist_i(hist), .cl6_i(cl6_i),
    .dq_en_o(dq_en), .beat_o(beat), .dqs_oe_o(dqs_oe_o),
    .dqs_o(dqs_o), .odt_off_o(odt_off_o)
  );

  assign pop = dq_en && (beat == BEAT_W'(BEATS - 1));

  rdseq_queue #(.WIDTH(ENT_W), .DEPTH(Q_D)) queue_i (
    .clk(clk), .rst_n(rst_n), .push_i(accept),
    .din_i({bank_i, col_i, rd_data_i}), .pop_i(pop), .head_o(head)
  );

  assign head_data = head[DATA_W-1:0];
  assign dq_oe_o   = dq_en;
  assign beat_o    = dq_en ? 2'(beat) : 2'd0;
  assign dq_o      = dq_en ? head_data[beat*DW +: DW] : '0;
  assign bank_o    = dq_en ? head[ENT_W-1 -: BANK_W] : '0;
  assign col_o     = dq_en ? head[DATA_W +: COL_W] : '0;
  assign rd_err_o  = reject;

  // R13: the phase alternates every fast-clock cycle.
  a_r13_phase_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q |=> !ph_q);
  // R11: an error never coincides with a newly recorded READ.
  a_r11_error_not_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err_o |-> !hist[0]);
endmodule

// File: tb/ddr_rd_seq_tb_top.sv
module ddr_rd_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_i = 1'b0;
  logic [2:0]  bank_i = '0;
  logic [9:0]  col_i = '0;
  logic [63:0] rd_data_i = '0;
  logic        cl6_i = 1'b0;
  logic        ph_o, dq_oe_o, dqs_o, dqs_oe_o, odt_off_o, rd_err_o;
  logic [15:0] dq_o;
  logic [1:0]  beat_o;
  logic [2:0]  bank_o;
  logic [9:0]  col_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_rd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .bank_i(bank_i), .col_i(col_i),
    .rd_data_i(rd_data_i), .cl6_i(cl6_i), .ph_o(ph_o), .dq_o(dq_o),
    .dq_oe_o(dq_oe_o), .beat_o(beat_o), .bank_o(bank_o), .col_o(col_o),
    .dqs_o(dqs_o), .dqs_oe_o(dqs_oe_o), .odt_off_o(odt_off_o), .rd_err_o(rd_err_o)
  );

  int vectors = 0;
  int misses = 0;
  int n = 0;
  bit done = 0;
  string scen = "";

  int          acc_s  [64];
  int          acc_cl [64];
  logic [63:0] acc_d  [64];
  logic [2:0]  acc_b  [64];
  logic [9:0]  acc_c  [64];
  int          n_acc = 0;
  int          last_s = -100;
  int          rej_s = -100;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s [%s] half=%0d actual=%0h expected=%0h", req, scen, n, act, exp);
    end
  endtask

  // Compare every output against values derived from the requirements.
  task automatic compare_now();
    logic e_dq_oe = 0, e_dqs_oe = 0, e_dqs = 0, e_odt = 0;
    logic [1:0]  e_beat = 0;
    logic [15:0] e_dq = 0;
    logic [2:0]  e_bank = 0;
    logic [9:0]  e_col = 0;
    for (int i = 0; i < n_acc; i++) begin
      int m = n - acc_s[i];
      int f = 2 * acc_cl[i] - 1;
      if (m >= f && m <= f + 3) begin
        e_dq_oe = 1;
        e_beat  = 2'(m - f);
        e_dq    = acc_d[i][(m - f)*DW +: DW];
        e_bank  = acc_b[i];
        e_col   = acc_c[i];
      end
      if (m >= f - 1 && m <= f + 3) e_dqs_oe = 1;
      if (m >= f - 2 && m <= f + 5) e_odt = 1;
    end
    e_dqs = e_dqs_oe && (e_dq_oe ? e_beat[0] : 1'b1);
    check("R13 phase", ph_o, n % 2);
    check("R2 dq_oe", dq_oe_o, e_dq_oe);
    check("R1 beat", beat_o, e_beat);
    check("R1 data", dq_o, e_dq);
    check("R1 bank", bank_o, e_bank);
    check("R1 col", col_o, e_col);
    check("R5/R7 dqs_oe", dqs_oe_o, e_dqs_oe);
    check("R6 dqs level", dqs_o, e_dqs);
    check("R8 odt_off", odt_off_o, e_odt);
    check("R11 rd_err", rd_err_o, n == rej_s);
  endtask

  task automatic tick();
    @(posedge clk);
    n++;
    @(negedge clk);
    compare_now();
  endtask

  task automatic idle(input int halves);
    for (int i = 0; i < halves; i++) tick();
  endtask

  // Present a READ in the next first-half interval.
  task automatic issue(input logic [2:0] b, input logic [9:0] c, input logic [63:0] d);
    if (ph_o) tick();
    rd_i = 1; bank_i = b; col_i = c; rd_data_i = d;
    if (n + 1 - last_s >= 4) begin
      acc_s[n_acc] = n + 1; acc_cl[n_acc] = cl6_i ? 6 : 5;
      acc_d[n_acc] = d; acc_b[n_acc] = b; acc_c[n_acc] = c;
      n_acc++;
      last_s = n + 1;
    end else begin
      rej_s = n + 1;
    end
    tick();
    rd_i = 0; bank_i = '0; col_i = '0; rd_data_i = '0;
  endtask

  task automatic t_reset();
    scen = "R13 R10 reset idle";
    compare_now();
    idle(6);
  endtask

  task automatic t_single(input logic cl6);
    scen = cl6 ? "R2 single CL6" : "R2 single CL5";
    cl6_i = cl6;
    issue(3'd1, 10'h055, 64'h4444_3333_2222_1111);
    idle(24);
  endtask

  task automatic t_gapless(input logic cl6, input logic same_bank);
    scen = same_bank ? "R3 R4 R9 gapless same bank" : "R3 R4 R9 gapless other bank";
    cl6_i = cl6;
    issue(3'd2, 10'h101, 64'hA0A3_A0A2_A0A1_A0A0);
    idle(2);
    issue(same_bank ? 3'd2 : 3'd5, 10'h202, 64'hB0B3_B0B2_B0B1_B0B0);
    idle(26);
  endtask

  task automatic t_spaced();
    scen = "R9 three-cycle spacing";
    cl6_i = 0;
    issue(3'd0, 10'h011, 64'hC003_C002_C001_C000);
    idle(4);
    issue(3'd7, 10'h3FF, 64'hD003_D002_D001_D000);
    idle(26);
  endtask

  task automatic t_too_close();
    scen = "R11 one-cycle spacing";
    cl6_i = 1;
    issue(3'd4, 10'h0AA, 64'hE003_E002_E001_E000);
    issue(3'd6, 10'h0BB, 64'hFFFF_FFFF_FFFF_FFFF);
    idle(28);
  endtask

  task automatic t_phase_one();
    scen = "R12 phase-one strobe";
    cl6_i = 0;
    if (!ph_o) tick();
    rd_i = 1; bank_i = 3'd3; col_i = 10'h123; rd_data_i = 64'h1234_5678_9ABC_DEF0;
    tick();
    rd_i = 0; bank_i = '0; col_i = '0; rd_data_i = '0;
    idle(24);
  endtask

  task automatic t_chain();
    scen = "R3 R9 four gapless CL6";
    cl6_i = 1;
    for (int j = 0; j < 4; j++) begin
      issue(3'(j), 10'(j * 3), {16'(j*4+3), 16'(j*4+2), 16'(j*4+1), 16'(j*4)});
      if (j < 3) idle(2);
    end
    idle(30);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single(0);
    t_single(1);
    t_gapless(0, 0);
    t_gapless(1, 1);
    t_spaced();
    t_too_close();
    t_phase_one();
    t_chain();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog [%s] actual=running expected=finished", scen);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule